// File: doc/BRIEF.md
# PCI Target Termination Controller

This block is the target-side cycle controller of a 32-bit PCI slave. For each transaction that the slave claims, it chooses one of three endings: it completes data phases normally, it retries the initiator before any data moves, or it stops the initiator part way through a burst without transferring the data phase in progress. The choice depends on handshake flags from a backend data port. These flags are a bus-grant flag and a busy flag, checked when the transaction starts, and separate read-ready and write-ready flags, checked during every data phase.

The controller watches FRAME# and IRDY# and an address-hit strobe. It claims the cycle with medium decode timing. It drives DEVSEL#, TRDY# and STOP#, and provides one enable per line for the pad tri-states. A wait counter bounds every data phase. The first data phase has a longer limit than the later ones. When a limit runs out, the controller ends the transaction as a disconnect without data. After each transaction it drives the three lines high for one clock, then releases them.

Top module: `pci_tgt_term`

## Requirements
- R1: The address clock is the first clock in which FRAME# is sampled low while the block is idle. If `addr_hit` is high in that clock, DEVSEL# goes low in the second clock after it. If `addr_hit` is low, all three lines stay high and all three enables stay low for that transaction.
- R2: If `be_gnt` or `be_busy` is high in the address clock, the block answers with a retry. STOP# and DEVSEL# go low together in the same clock, TRDY# stays high, and no data phase completes.
- R3: STOP# and TRDY# are never low in the same clock. STOP# is never low while DEVSEL# is high.
- R4: `wr_cycle` is sampled in the address clock, where 1 means write. TRDY# may be low only during a data phase, and only while the selected ready flag is high. A write selects `wr_rdy` and a read selects `rd_rdy`. The unselected flag has no effect.
- R5: A data phase completes on the clock edge where TRDY# and IRDY# are both low. If FRAME# is high on that edge, the transaction ends and the turnaround clock follows.
- R6: If the first data phase does not complete within 16 clocks, the block signals a disconnect without data. STOP# goes low in the 17th clock of that phase, and TRDY# stays high from then on.
- R7: Every later data phase has an 8-clock limit. With no completion, STOP# goes low in the 9th clock of that phase.
- R8: Once STOP# is low, STOP# and DEVSEL# stay low through the clock in which the initiator has released both FRAME# and IRDY#. They stay low while either of those lines is still low.
- R9: After each claimed transaction, the block drives DEVSEL#, TRDY# and STOP# high with their enables on for exactly one clock. In the next clock all enables are low, and the block is idle and ready for a new address clock.
- R10: While `rst_n` is low, all three lines read high and all enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | FRAME# from the initiator |
| irdy_n | input | 1 | IRDY# from the initiator |
| addr_hit | input | 1 | Address decoder says the cycle targets this slave |
| wr_cycle | input | 1 | Command is a write (1) or a read (0), valid in the address clock |
| be_gnt | input | 1 | Backend holds its own bus grant |
| be_busy | input | 1 | Backend cannot take a new transaction |
| rd_rdy | input | 1 | Backend can supply read data |
| wr_rdy | input | 1 | Backend can accept write data |
| devsel_n | output | 1 | DEVSEL# drive value |
| trdy_n | output | 1 | TRDY# drive value |
| stop_n | output | 1 | STOP# drive value |
| devsel_oe | output | 1 | Output enable for DEVSEL# |
| trdy_oe | output | 1 | Output enable for TRDY# |
| stop_oe | output | 1 | Output enable for STOP# |

## Verification
The bench runs two retries: one caused only by the grant flag on a read, and one caused only by the busy flag on a write. In both, the ready flags are raised to show that TRDY# stays high. It runs a write burst with wait states while the read-ready flag is held high against it, and a short read burst. Together these separate correct ready selection and completion on FRAME# release from a controller that ignores the direction. It also runs an unclaimed cycle, and two timeout disconnects, one in the first data phase and one in a later phase. The two timeout cases tell apart the 16-clock and 8-clock limits, and they also test that STOP# is held while the initiator releases FRAME# and IRDY# slowly, one after the other.

// File: rtl/pci_tgt_term.sv
module pci_tgt_term #(
  parameter int FIRST_LIMIT = 16,
  parameter int NEXT_LIMIT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic addr_hit,
  input  logic wr_cycle,
  input  logic be_gnt,
  input  logic be_busy,
  input  logic rd_rdy,
  input  logic wr_rdy,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic devsel_oe,
  output logic trdy_oe,
  output logic stop_oe
);

  localparam int CW = $clog2(FIRST_LIMIT + NEXT_LIMIT + 1);

  typedef enum logic [2:0] {IDLE, B_BUSY, S_DATA, BACKOFF, TURN_AR} st_t;

  st_t           st;
  logic          frame_d, wr_q, retry_q, first_q;
  logic [CW-1:0] cnt;

  wire           addr_ph = (st == IDLE) && !frame_n && frame_d;
  wire           rdy_sel = wr_q ? wr_rdy : rd_rdy;
  wire           xfer    = (st == S_DATA) && rdy_sel && !irdy_n;
  wire [CW-1:0]  lim     = first_q ? CW'(FIRST_LIMIT - 1) : CW'(NEXT_LIMIT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      frame_d <= 1'b1;
      wr_q    <= 1'b0;
      retry_q <= 1'b0;
      first_q <= 1'b1;
      cnt     <= '0;
    end else begin
      frame_d <= frame_n;
      case (st)
        IDLE: if (addr_ph && addr_hit) begin
          st      <= B_BUSY;
          wr_q    <= wr_cycle;
          retry_q <= be_gnt | be_busy;
        end
        B_BUSY: begin
          cnt     <= '0;
          first_q <= 1'b1;
          st      <= retry_q ? BACKOFF : S_DATA;
        end
        S_DATA: begin
          if (xfer) begin
            if (frame_n) st <= TURN_AR;
            cnt     <= '0;
            first_q <= 1'b0;
          end else if (cnt == lim) begin
            st <= BACKOFF;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        BACKOFF: if (irdy_n && frame_n) st <= TURN_AR;
        TURN_AR: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  wire drive = (st == S_DATA) || (st == BACKOFF) || (st == TURN_AR);

  assign devsel_n  = !((st == S_DATA) || (st == BACKOFF));
  assign stop_n    = (st != BACKOFF);
  assign trdy_n    = !((st == S_DATA) && rdy_sel);
  assign devsel_oe = drive;
  assign trdy_oe   = drive;
  assign stop_oe   = drive;

  assert_medium_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ph && addr_hit) |=> devsel_n ##1 !devsel_n);

  assert_no_claim_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ph && !addr_hit) |=> !devsel_oe);

  assert_retry_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ph && addr_hit && (be_gnt || be_busy)) |=> ##1 (!stop_n && !devsel_n && trdy_n));

  assert_stop_trdy_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> (trdy_n && !devsel_n));

  assert_write_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && wr_q) |-> wr_rdy);

  assert_read_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !wr_q) |-> rd_rdy);

  assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (cnt < CW'(FIRST_LIMIT)));

  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !(irdy_n && frame_n)) |=> !stop_n);

  assert_turn_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_n) |-> (devsel_n && trdy_n && stop_oe));

  assert_turn_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TURN_AR) |=> (!devsel_oe && !trdy_oe && !stop_oe));

endmodule

// File: tb/pci_tgt_term_test.sv
module pci_tgt_term_test;
  localparam int PER = 10;
  localparam logic [3:0] E_IDLE = 4'b1110;
  localparam logic [3:0] E_WAIT = 4'b0111;
  localparam logic [3:0] E_XFER = 4'b0011;
  localparam logic [3:0] E_STOP = 4'b0101;
  localparam logic [3:0] E_TURN = 4'b1111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1;
  logic addr_hit = 1'b0, wr_cycle = 1'b0, be_gnt = 1'b0, be_busy = 1'b0;
  logic rd_rdy = 1'b0, wr_rdy = 1'b0;
  logic devsel_n, trdy_n, stop_n, devsel_oe, trdy_oe, stop_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [3:0] e; string tag; } item_t;
  item_t q[$];

  always #(PER/2) clk = ~clk;

  pci_tgt_term uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .addr_hit(addr_hit), .wr_cycle(wr_cycle), .be_gnt(be_gnt), .be_busy(be_busy),
    .rd_rdy(rd_rdy), .wr_rdy(wr_rdy), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .devsel_oe(devsel_oe), .trdy_oe(trdy_oe), .stop_oe(stop_oe)
  );

  // s = {addr_hit, wr_cycle, be_gnt, be_busy, rd_rdy, wr_rdy}
  // e = {devsel_n, trdy_n, stop_n, enables}
  task automatic cyc(input logic f, input logic i, input logic [5:0] s,
                     input logic [3:0] e, input string tag);
    item_t it;
    @(negedge clk);
    frame_n = f; irdy_n = i;
    {addr_hit, wr_cycle, be_gnt, be_busy, rd_rdy, wr_rdy} = s;
    it.e = e; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    logic [3:0] got;
    forever begin
      @(negedge clk);
      #(PER/4);
      if (q.size() > 0) begin
        it = q.pop_front();
        got = {devsel_n, trdy_n, stop_n, devsel_oe};
        checks++;
        if (got !== it.e || trdy_oe !== devsel_oe || stop_oe !== devsel_oe) begin
          errors++;
          $display("FAIL %s: got dev/trdy/stop/oe=%b (oe t/s=%b%b) expected %b",
                   it.tag, got, trdy_oe, stop_oe, it.e);
        end
        checks++;
        if (!trdy_n && !stop_n) begin
          errors++;
          $display("FAIL R3: trdy_n=%b stop_n=%b expected not both 0", trdy_n, stop_n);
        end
      end
    end
  end

  initial begin : watchdog
    #(PER*50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run not finished, got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    // R10 reset state
    for (int k = 0; k < 3; k++) cyc(1, 1, 6'b000000, E_IDLE, "R10");
    rst_n = 1'b1;
    cyc(1, 1, 6'b000000, E_IDLE, "R10");

    // R2 retry from grant, read; ready flags high must not raise TRDY#
    cyc(0, 1, 6'b101000, E_IDLE, "R1");
    cyc(0, 0, 6'b101000, E_IDLE, "R1");
    cyc(0, 0, 6'b101011, E_STOP, "R2");
    cyc(1, 0, 6'b101011, E_STOP, "R8");
    cyc(1, 1, 6'b101011, E_STOP, "R8");
    cyc(1, 1, 6'b000000, E_TURN, "R9");
    cyc(1, 1, 6'b000000, E_IDLE, "R9");

    // R2 retry from busy, write
    cyc(0, 1, 6'b110100, E_IDLE, "R1");
    cyc(0, 0, 6'b110100, E_IDLE, "R1");
    cyc(0, 0, 6'b110111, E_STOP, "R2");
    cyc(1, 0, 6'b110111, E_STOP, "R8");
    cyc(1, 1, 6'b000000, E_STOP, "R8");
    cyc(1, 1, 6'b000000, E_TURN, "R9");
    cyc(1, 1, 6'b000000, E_IDLE, "R9");

    // R4/R5 write burst, three phases, wait states with only rd_rdy high
    cyc(0, 1, 6'b110001, E_IDLE, "R1");
    cyc(0, 0, 6'b110001, E_IDLE, "R1");
    cyc(0, 0, 6'b110001, E_XFER, "R4");
    cyc(0, 0, 6'b110010, E_WAIT, "R4");
    cyc(0, 0, 6'b110010, E_WAIT, "R4");
    cyc(0, 0, 6'b110001, E_XFER, "R5");
    cyc(1, 0, 6'b110001, E_XFER, "R5");
    cyc(1, 1, 6'b000000, E_TURN, "R9");
    cyc(1, 1, 6'b000000, E_IDLE, "R9");

    // R4/R5 read burst, two phases
    cyc(0, 1, 6'b100010, E_IDLE, "R1");
    cyc(0, 0, 6'b100010, E_IDLE, "R1");
    cyc(0, 0, 6'b100010, E_XFER, "R4");
    cyc(1, 0, 6'b100010, E_XFER, "R5");
    cyc(1, 1, 6'b000000, E_TURN, "R9");
    cyc(1, 1, 6'b000000, E_IDLE, "R9");

    // R1 address miss: nothing is driven
    cyc(0, 1, 6'b000011, E_IDLE, "R1");
    for (int k = 0; k < 3; k++) cyc(0, 0, 6'b000011, E_IDLE, "R1");
    cyc(1, 0, 6'b000011, E_IDLE, "R1");
    cyc(1, 1, 6'b000000, E_IDLE, "R1");

    // R6 first-phase timeout on a read
    cyc(0, 1, 6'b100000, E_IDLE, "R1");
    cyc(0, 0, 6'b100000, E_IDLE, "R1");
    for (int k = 0; k < 16; k++) cyc(0, 0, 6'b100000, E_WAIT, "R6");
    cyc(0, 0, 6'b100010, E_STOP, "R6");
    cyc(1, 0, 6'b100010, E_STOP, "R8");
    cyc(1, 1, 6'b100010, E_STOP, "R8");
    cyc(1, 1, 6'b000000, E_TURN, "R9");
    cyc(1, 1, 6'b000000, E_IDLE, "R9");

    // R7 later-phase timeout on a write, slow initiator release
    cyc(0, 1, 6'b110001, E_IDLE, "R1");
    cyc(0, 0, 6'b110001, E_IDLE, "R1");
    cyc(0, 0, 6'b110001, E_XFER, "R5");
    for (int k = 0; k < 8; k++) cyc(0, 0, 6'b110000, E_WAIT, "R7");
    cyc(0, 0, 6'b110001, E_STOP, "R7");
    cyc(0, 0, 6'b110001, E_STOP, "R8");
    cyc(0, 0, 6'b110001, E_STOP, "R8");
    cyc(1, 0, 6'b110001, E_STOP, "R8");
    cyc(1, 1, 6'b000000, E_STOP, "R8");
    cyc(1, 1, 6'b000000, E_TURN, "R9");
    cyc(1, 1, 6'b000000, E_IDLE, "R9");
    cyc(1, 1, 6'b000000, E_IDLE, "R9");

    @(negedge clk);
    @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule